// File: doc/BRIEF.md
# Deferred Multi-Bank Aggressor Refresh Manager

This block sits on the memory-controller side of a randomized aggressor-row tracker. Every activation that arrives with a bank and a row is put through a probability gate driven by an external random value. A bank whose gate fires keeps that row in its own slot and does not ask for a refresh at once. The block waits so that other banks can catch samples of their own. It then raises one directed-refresh request that covers every bank holding a row.

While a request is being deferred, each bank's slot counts further activations to its held row. When that count reaches a cap, the request goes out early, so the deferral can never hide more than a bounded amount of hammering. A programmable delay timer, started by the first sample of a group, also sends the request out when nothing else does.

The request is a one-cycle pulse. It carries a per-bank mask and the held rows, and these stay on the outputs until the scheduler acknowledges. Only after the acknowledge does the block start collecting a new group.

Top module: `rbm_refresh_batcher`

## Requirements
- R1: During and right after reset, `refresh_req` is low and `refresh_mask` and `refresh_rows` are all zero.
- R2: An activation to a bank with no held row is sampled only when `rand_val` is strictly below the parameter `SAMPLE_NUM`; a sample stores the row in that bank's slot.
- R3: A bank that already holds a row ignores further samples, so its held row does not change until the group is refreshed.
- R4: With no cap event, `refresh_req` is high in the cycle that begins `cfg_delay`+1 rising edges after the edge that stored the group's first sample, whatever activations arrive in between.
- R5: Each activation to a bank's held row, whatever its random value, adds one to that bank's count. Activations to other rows or other banks do not count. The clock edge after the count reaches `CAP` raises `refresh_req`.
- R6: Bit b of `refresh_mask` is set exactly for the banks holding a row. Bank b's row is placed at bits [b*ROW_W +: ROW_W] of `refresh_rows`, and the slices of banks without a row are zero.
- R7: `refresh_req` is high for exactly one cycle, and `refresh_mask` and `refresh_rows` stay unchanged until `refresh_ack` is seen.
- R8: The edge that raises `refresh_req` clears every slot, count and the delay timer. After the acknowledge, a bank from the previous group samples a new row and the timer restarts from zero.
- R9: Activations arriving from the cycle in which the request is triggered up to and including the cycle carrying `refresh_ack` are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| act_valid | input | 1 | An activation is present this cycle |
| act_bank | input | $clog2(NB) | Bank of the activation |
| act_row | input | ROW_W | Row of the activation |
| rand_val | input | RND_W | Random value for the sampling gate |
| cfg_delay | input | DLY_W | Deferral in cycles after the group's first sample |
| refresh_req | output | 1 | One-cycle directed-refresh request |
| refresh_mask | output | NB | Banks to be mitigated, bit b is bank b |
| refresh_rows | output | NB*ROW_W | Held rows, bank b at [b*ROW_W +: ROW_W] |
| refresh_ack | input | 1 | Scheduler accepted the request |

## Verification
The bench builds the block with four banks, 12-bit rows, an 8-bit random value, `SAMPLE_NUM` of 3 and a monitor cap of 3. The small cap lets an early issue be forced in a handful of activations, and the small bank count lets the mask and every row slice be checked for all banks. The threshold of 3 puts the sampling boundary at values 2 and 3, which the bench drives directly. Because `cfg_delay` is a port, both the zero-delay case and a delay long enough to keep out of the way of the cap test come from one build.

// File: rtl/rbm_pkg.sv
// Package: shared types of the deferred refresh manager.
// Assumes: nothing beyond IEEE 1800-2017.
package rbm_pkg;
    // Collect samples, or hold a request until the scheduler acknowledges.
    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_WAIT    = 1'b1
    } rbm_state_e;
endpackage

// File: rtl/rbm_sampler.sv
// Module: rbm_sampler
// Decodes the activation bank into a per-bank strobe and applies the
// probability gate (rand_val below SAMPLE_NUM). Assumes NB >= 2 and that the
// caller gates activations with 'accept' while a request is outstanding.
module rbm_sampler #(
    parameter int NB         = 8,
    parameter int RND_W      = 8,
    parameter int SAMPLE_NUM = 3,
    localparam int BANK_W    = $clog2(NB)
) (
    input  logic              accept,
    input  logic              act_valid,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [RND_W-1:0]  rand_val,
    output logic [NB-1:0]     touch_vec,
    output logic              take
);
    // Probability gate shared by all banks.
    assign take = rand_val < RND_W'(SAMPLE_NUM);

    for (genvar b = 0; b < NB; b++) begin : g_dec
        // Strobe for bank b when an accepted activation addresses it.
        assign touch_vec[b] = accept && act_valid && (act_bank == BANK_W'(b));
    end
endmodule

// File: rtl/rbm_bank_slot.sv
// Module: rbm_bank_slot
// One bank's aggressor slot: held row, valid bit and a saturating counter of
// activations to the held row (the target-row monitor). Assumes 'clear' has
// priority over any activation in the same cycle.
module rbm_bank_slot #(
    parameter int ROW_W  = 16,
    parameter int CAP    = 4,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic             take,
    input  logic [ROW_W-1:0] row_in,
    input  logic             clear,
    output logic             valid_o,
    output logic [ROW_W-1:0] row_o,
    output logic             at_cap_o
);
    logic [CNT_W-1:0] cnt_q;

    // Monitor has reached its cap.
    assign at_cap_o = valid_o && (cnt_q == CNT_W'(CAP));

    // Load a sample, count repeat hits, or clear on refresh issue.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid_o <= 1'b0;
            row_o   <= '0;
            cnt_q   <= '0;
        end else if (touch) begin
            if (!valid_o && take) begin
                valid_o <= 1'b1;
                row_o   <= row_in;
                cnt_q   <= '0;
            end else if (valid_o && (row_in == row_o) && !at_cap_o) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rbm_batch_ctl.sv
// Module: rbm_batch_ctl
// Group controller: delay timer from the first sample, trigger on timer or
// any monitor cap, one-cycle request pulse with latched mask and rows, then
// wait for acknowledge. Assumes slot rows read zero when the slot is empty.
module rbm_batch_ctl
    import rbm_pkg::*;
#(
    parameter int NB    = 8,
    parameter int ROW_W = 16,
    parameter int DLY_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NB-1:0]       valid_vec,
    input  logic [NB-1:0]       cap_vec,
    input  logic [NB*ROW_W-1:0] rows_in,
    input  logic [DLY_W-1:0]    cfg_delay,
    input  logic                ack,
    output logic                accept,
    output logic                clear,
    output logic                waiting,
    output logic                req,
    output logic [NB-1:0]       mask,
    output logic [NB*ROW_W-1:0] rows
);
    rbm_state_e       state_q;
    logic [DLY_W-1:0] timer_q;
    logic             any_valid;
    logic             fire;

    // Trigger when a group exists and either the timer or a monitor expired.
    assign any_valid = |valid_vec;
    assign waiting   = (state_q == ST_WAIT);
    assign fire      = !waiting && any_valid && ((timer_q >= cfg_delay) || (|cap_vec));
    assign clear     = fire;
    assign accept    = !waiting && !fire;

    // Delay timer: runs while a group is held, saturates, restarts on issue.
    always_ff @(posedge clk) begin
        if (!rst_n || fire || !any_valid) begin
            timer_q <= '0;
        end else if (timer_q != {DLY_W{1'b1}}) begin
            timer_q <= timer_q + 1'b1;
        end
    end

    // Request pulse and hand-over state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
            req     <= 1'b0;
        end else begin
            req <= fire;
            if (fire) begin
                state_q <= ST_WAIT;
            end else if (waiting && ack) begin
                state_q <= ST_COLLECT;
            end
        end
    end

    // Latch the group snapshot on issue and hold it through the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            rows <= '0;
        end else if (fire) begin
            mask <= valid_vec;
            rows <= rows_in;
        end
    end
endmodule

// File: rtl/rbm_refresh_batcher.sv
// Module: rbm_refresh_batcher (top)
// Deferred multi-bank aggressor refresh manager: per-bank probabilistic
// sampling, per-bank target-row monitors, one batched refresh request.
// Assumes the scheduler answers every request with refresh_ack.
module rbm_refresh_batcher #(
    parameter int NB         = 8,
    parameter int ROW_W      = 16,
    parameter int RND_W      = 8,
    parameter int SAMPLE_NUM = 3,
    parameter int CAP        = 4,
    parameter int DLY_W      = 8,
    localparam int BANK_W    = $clog2(NB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                act_valid,
    input  logic [BANK_W-1:0]   act_bank,
    input  logic [ROW_W-1:0]    act_row,
    input  logic [RND_W-1:0]    rand_val,
    input  logic [DLY_W-1:0]    cfg_delay,
    output logic                refresh_req,
    output logic [NB-1:0]       refresh_mask,
    output logic [NB*ROW_W-1:0] refresh_rows,
    input  logic                refresh_ack
);
    logic [NB-1:0]       touch_vec;
    logic [NB-1:0]       valid_vec;
    logic [NB-1:0]       cap_vec;
    logic [NB*ROW_W-1:0] rows_flat;
    logic                take;
    logic                accept;
    logic                clear;
    logic                waiting;

    rbm_sampler #(
        .NB(NB), .RND_W(RND_W), .SAMPLE_NUM(SAMPLE_NUM)
    ) u_sampler (
        .accept(accept), .act_valid(act_valid), .act_bank(act_bank),
        .rand_val(rand_val), .touch_vec(touch_vec), .take(take)
    );

    for (genvar b = 0; b < NB; b++) begin : g_slot
        rbm_bank_slot #(.ROW_W(ROW_W), .CAP(CAP)) u_slot (
            .clk(clk), .rst_n(rst_n), .touch(touch_vec[b]), .take(take),
            .row_in(act_row), .clear(clear), .valid_o(valid_vec[b]),
            .row_o(rows_flat[b*ROW_W +: ROW_W]), .at_cap_o(cap_vec[b])
        );
    end

    rbm_batch_ctl #(.NB(NB), .ROW_W(ROW_W), .DLY_W(DLY_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .cap_vec(cap_vec),
        .rows_in(rows_flat), .cfg_delay(cfg_delay), .ack(refresh_ack),
        .accept(accept), .clear(clear), .waiting(waiting),
        .req(refresh_req), .mask(refresh_mask), .rows(refresh_rows)
    );
endmodule

// File: rtl/rbm_refresh_batcher_chk.sv
// Module: rbm_refresh_batcher_chk
// Property checker bound to the top module. Assumes synchronous active-low reset.
module rbm_refresh_batcher_chk #(
    parameter int NB    = 8,
    parameter int ROW_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req,
    input logic                ack,
    input logic [NB-1:0]       mask,
    input logic [NB*ROW_W-1:0] rows,
    input logic [NB-1:0]       valid_vec,
    input logic                waiting
);
    // R7: request is a single-cycle pulse.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    // R7: snapshot held until acknowledge.
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !ack) |=> ($stable(mask) && $stable(rows)));
    // R6: a request always names at least one bank.
    a_r6_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (mask != '0));
    // R8: slots are empty in the cycle the request is seen.
    a_r8_cleared_at_issue: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (valid_vec == '0));
    // R9: no sample is captured while waiting for acknowledge.
    a_r9_no_capture_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |=> (valid_vec == '0));
    // R4: a request is only raised for a held group.
    a_r4_req_needs_group: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(valid_vec != '0));
endmodule

bind rbm_refresh_batcher rbm_refresh_batcher_chk #(.NB(NB), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(refresh_req), .ack(refresh_ack),
    .mask(refresh_mask), .rows(refresh_rows), .valid_vec(valid_vec),
    .waiting(waiting)
);

// File: tb/rbm_refresh_batcher_test.sv
module rbm_refresh_batcher_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4, ROW_W = 12, RND_W = 8, SNUM = 3, CAP = 3, DLY_W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                act_valid = 1'b0;
    logic [1:0]          act_bank = '0;
    logic [ROW_W-1:0]    act_row = '0;
    logic [RND_W-1:0]    rand_val = '1;
    logic [DLY_W-1:0]    cfg_delay = '0;
    logic                refresh_req;
    logic [NB-1:0]       refresh_mask;
    logic [NB*ROW_W-1:0] refresh_rows;
    logic                refresh_ack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbm_refresh_batcher #(
        .NB(NB), .ROW_W(ROW_W), .RND_W(RND_W), .SAMPLE_NUM(SNUM),
        .CAP(CAP), .DLY_W(DLY_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bank(act_bank),
        .act_row(act_row), .rand_val(rand_val), .cfg_delay(cfg_delay),
        .refresh_req(refresh_req), .refresh_mask(refresh_mask),
        .refresh_rows(refresh_rows), .refresh_ack(refresh_ack)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One activation, one clock edge; entered and left at a negedge.
    task automatic do_act(input int b, input int r, input int rnd);
        act_valid = 1'b1;
        act_bank  = 2'(b);
        act_row   = ROW_W'(r);
        rand_val  = RND_W'(rnd);
        @(negedge clk);
        act_valid = 1'b0;
        rand_val  = '1;
    endtask

    // Cycles until refresh_req is seen (0 if not within max).
    task automatic wait_req(input int max, output int n);
        n = 0;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (refresh_req) begin
                n = i;
                return;
            end
        end
    endtask

    task automatic do_ack();
        refresh_ack = 1'b1;
        @(negedge clk);
        refresh_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(refresh_req == 1'b0, "R1 req in reset", refresh_req, 0);
        check(refresh_mask == '0, "R1 mask in reset", refresh_mask, 0);
        check(refresh_rows == '0, "R1 rows in reset", refresh_rows, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(refresh_req == 1'b0, "R1 req after reset", refresh_req, 0);
    endtask

    task automatic t_sample_gate();
        int n;
        cfg_delay = 8'd4;
        do_act(1, 'h0AB, SNUM);
        wait_req(20, n);
        check(n == 0, "R2 rand==SAMPLE_NUM not sampled", n, 0);
        do_act(1, 'h0AC, SNUM - 1);
        wait_req(20, n);
        check(n == 5, "R4 delay 4 issue cycle", n, 5);
        check(refresh_mask == 4'b0010, "R2 mask bank1", refresh_mask, 4'b0010);
        check(refresh_rows[1*ROW_W +: ROW_W] == 12'h0AC, "R2 row bank1",
              refresh_rows[1*ROW_W +: ROW_W], 'h0AC);
        do_ack();
    endtask

    task automatic t_delay();
        int n;
        cfg_delay = 8'd0;
        do_act(3, 'h123, 0);
        wait_req(20, n);
        check(n == 1, "R4 zero delay", n, 1);
        do_ack();
        cfg_delay = 8'd7;
        do_act(3, 'h456, 0);
        wait_req(20, n);
        check(n == 8, "R8 timer restarts", n, 8);
        check(refresh_rows[3*ROW_W +: ROW_W] == 12'h456, "R8 new row after ack",
              refresh_rows[3*ROW_W +: ROW_W], 'h456);
        do_ack();
    endtask

    task automatic t_batch();
        int n;
        logic [NB*ROW_W-1:0] exp_rows;
        logic [NB-1:0]       m0;
        cfg_delay = 8'd6;
        do_act(0, 'h111, 0);
        do_act(2, 'h222, 1);
        do_act(0, 'h999, 0);
        wait_req(20, n);
        check(n == 5, "R4 timer under activity", n, 5);
        exp_rows = {12'h000, 12'h222, 12'h000, 12'h111};
        check(refresh_mask == 4'b0101, "R6 mask", refresh_mask, 4'b0101);
        check(refresh_rows == exp_rows, "R6 rows and R3 held row kept", refresh_rows, exp_rows);
        m0 = refresh_mask;
        @(negedge clk);
        check(refresh_req == 1'b0, "R7 single pulse", refresh_req, 0);
        check(refresh_mask == m0 && refresh_rows == exp_rows, "R7 held before ack",
              refresh_rows, exp_rows);
        do_ack();
    endtask

    task automatic t_monitor();
        int n;
        cfg_delay = 8'd200;
        do_act(2, 'h0F0, 0);
        do_act(2, 'h0F0, 255);
        do_act(2, 'h0F1, 255);
        do_act(1, 'h0F0, 255);
        do_act(2, 'h0F0, 255);
        wait_req(10, n);
        check(n == 0, "R5 other rows not counted", n, 0);
        do_act(2, 'h0F0, 255);
        wait_req(5, n);
        check(n == 1, "R5 cap forces issue", n, 1);
        check(refresh_mask == 4'b0100, "R5 mask", refresh_mask, 4'b0100);
        do_ack();
    endtask

    task automatic t_wait_ignore();
        int n;
        cfg_delay = 8'd2;
        do_act(0, 'h0AA, 0);
        wait_req(20, n);
        check(n == 3, "R4 delay 2", n, 3);
        do_act(1, 'h0BB, 0);
        check(refresh_mask == 4'b0001, "R7 mask held while waiting", refresh_mask, 4'b0001);
        do_ack();
        wait_req(40, n);
        check(n == 0, "R9 activation while waiting dropped", n, 0);
        do_act(0, 'h0CC, 0);
        wait_req(20, n);
        check(n == 3, "R8 fresh group after ack", n, 3);
        check(refresh_rows[0 +: ROW_W] == 12'h0CC && refresh_mask == 4'b0001,
              "R8 bank0 resampled", refresh_rows[0 +: ROW_W], 'h0CC);
        do_ack();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sample_gate();
        t_delay();
        t_batch();
        t_monitor();
        t_wait_ignore();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule